// File: doc/BRIEF.md
# Masked Dual-Rail Majority AND Datapath

This block computes a bitwise three-operand AND, `y = a & b & c`. Each data bit travels through the datapath as a complementary rail pair that also carries a random mask. A single mask bit is shared by every gate. Encoders at the inputs turn each plain operand bit into the pair (d XOR m, NOT(d XOR m)). The mask itself is sent out as its own pair (m, NOT m). Every gate is built from two majority functions: the true rail is MAJ of the true input rails and the mask true rail, and the false rail is MAJ of the false rails and the mask false rail. The result is the masked AND, with the same mask bit as the inputs.

Work proceeds in alternating phases, selected by `eval_i`. In precharge, every rail pair returns to 00. In evaluation, the encoders release the pairs of the operands whose drive input is set. Each gate has its own completion stage, which holds the gate output in a register:
- The output leaves 00 only once all of the gate's input pairs are valid, including the mask pair.
- A valid output returns to 00 only once all of those input pairs are 00 again.

This prevents a gate from evaluating early (for example, an AND resolving to 0 as soon as one input is known to be 0) and from precharging early. The mask comes from an LFSR. The LFSR steps on each clock of the precharge phase once the whole gate tree has returned to 00, and holds through evaluation. The output decoder removes the mask to give plain data, and also exposes the raw masked rails of the last gate level.

Top module: `mdr_and3`

## Requirements
- R1: While reset is held and after it is released, with `eval_i` low, `y_t_o`, `y_f_o`, `y_o` and `y_vld_o` are all zero.
- R2: With `eval_i` high and all three drive inputs set, every bit of `y_vld_o` is 1 two clock edges later, and `y_o` equals `a_i & b_i & c_i`.
- R3: Each output bit pair (`y_t_o[i]`, `y_f_o[i]`) is either 00 (precharged) or complementary (valid); it is never 11.
- R4: All valid bits share one mask bit: when evaluated, `y_t_o` equals either `y_o` or `~y_o` across the whole word.
- R5: The mask steps once per clock while `eval_i` is low and every gate pair is 00. It is held otherwise, so it never changes while any output is valid. Over repeated rounds with identical data, the masked true rails take both polarities.
- R6: A gate stays at 00 until every one of its input pairs is valid. An undriven operand keeps its pair at 00, so with one operand undriven `y_vld_o` stays 0, even when a driven operand is 0. It becomes valid one edge after the last pair of the final gate level arrives.
- R7: Once evaluated, an output stays valid and unchanged until all of its input pairs, including the mask pair, are 00. Removing operand drives while `eval_i` stays high therefore leaves `y_o` and `y_vld_o` unchanged.
- R8: Operand data that changes after evaluation, while drives and `eval_i` stay high, has no effect on `y_o` until the next precharge.
- R9: After `eval_i` falls with all operands undriven, `y_vld_o` and both rail outputs are 0 two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | 1 = evaluation phase, 0 = precharge phase |
| a_drv_i | input | 1 | Release operand a rails during evaluation |
| b_drv_i | input | 1 | Release operand b rails during evaluation |
| c_drv_i | input | 1 | Release operand c rails during evaluation |
| a_i | input | W | Operand a, plain data |
| b_i | input | W | Operand b, plain data |
| c_i | input | W | Operand c, plain data |
| y_o | output | W | Unmasked result, 0 where not valid |
| y_vld_o | output | W | Per-bit completion of the final gate level |
| y_t_o | output | W | Masked true rails of the final gate level |
| y_f_o | output | W | Masked false rails of the final gate level |

## Verification
The bench uses the default parameters:
- A 4-bit word, so its vector table can place 0 and 1 in each bit position of each operand, and each AND gate meets every mix of input values across one word.
- An 8-bit maximal LFSR, whose low bit changes within a few precharge steps. Sixteen rounds with identical data are therefore enough to see both mask polarities on the true rails.

Staggered drive patterns put the last arriving pair at the first gate level and at the second. They show that no gate resolves from a partial set of inputs and that no valid output collapses while the mask pair is still present.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    // three-input majority, the basic cell of every gate
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/mdr_mask_src.sv
module mdr_mask_src #(
    parameter int            LW   = 8,
    parameter logic [LW-1:0] TAPS = 8'hB8,
    parameter logic [LW-1:0] SEED = 8'h5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic mask_o
);

    typedef struct packed {
        logic [LW-1:0] lfsr;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.lfsr & TAPS);
        if (step_i) begin
            st_d.lfsr = {st_q.lfsr[LW-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.lfsr[0];

    AST_MASK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (st_q.lfsr != $past(st_q.lfsr)));                       // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q.lfsr));                                   // R5
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);                                                  // R5

endmodule

// File: rtl/mdr_encoder.sv
module mdr_encoder #(
    parameter int W = 4
) (
    input  logic         drv_i,
    input  logic         mask_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] t_o,
    output logic [W-1:0] f_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic masked;
        always_comb begin
            masked = d_i[i] ^ mask_i;
            t_o[i] = drv_i & masked;
            f_o[i] = drv_i & ~masked;
        end
    end

endmodule

// File: rtl/mdr_maj_gate.sv
module mdr_maj_gate #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_t_i,
    input  logic [W-1:0] a_f_i,
    input  logic [W-1:0] b_t_i,
    input  logic [W-1:0] b_f_i,
    input  logic         m_t_i,
    input  logic         m_f_i,
    output logic [W-1:0] q_t_o,
    output logic [W-1:0] q_f_o
);
    import mdr_pkg::*;

    typedef struct packed {
        logic [W-1:0] t;
        logic [W-1:0] f;
    } pair_vec_t;

    pair_vec_t    st_d, st_q;
    logic [W-1:0] all_vld;
    logic [W-1:0] all_zero;
    logic         m_vld;
    logic         m_zero;

    // completion detection: evaluate on full arrival, precharge on full return
    always_comb begin
        st_d   = st_q;
        m_vld  = m_t_i ^ m_f_i;
        m_zero = ~(m_t_i | m_f_i);
        for (int i = 0; i < W; i++) begin
            all_vld[i]  = (a_t_i[i] ^ a_f_i[i]) & (b_t_i[i] ^ b_f_i[i]) & m_vld;
            all_zero[i] = ~(a_t_i[i] | a_f_i[i]) & ~(b_t_i[i] | b_f_i[i]) & m_zero;
            if (!(st_q.t[i] | st_q.f[i])) begin
                if (all_vld[i]) begin
                    st_d.t[i] = maj3(a_t_i[i], b_t_i[i], m_t_i);
                    st_d.f[i] = maj3(a_f_i[i], b_f_i[i], m_f_i);
                end
            end else if (all_zero[i]) begin
                st_d.t[i] = 1'b0;
                st_d.f[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_t_o = st_q.t;
    assign q_f_o = st_q.f;

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_NO_EARLY_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
            (!(st_q.t[i] | st_q.f[i]) && !all_vld[i]) |=> !(st_q.t[i] | st_q.f[i]));  // R6
        AST_NO_EARLY_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
            ((st_q.t[i] ^ st_q.f[i]) && !all_zero[i]) |=> $stable(st_q.t[i]) && $stable(st_q.f[i])); // R7
        AST_RAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.t[i] & st_q.f[i]));                                                 // R3
    end

endmodule

// File: rtl/mdr_and3.sv
module mdr_and3 #(
    parameter int               W       = 4,
    parameter int               MASK_W  = 8,
    parameter logic [MASK_W-1:0] MASK_TAPS = 8'hB8,
    parameter logic [MASK_W-1:0] MASK_SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval_i,
    input  logic         a_drv_i,
    input  logic         b_drv_i,
    input  logic         c_drv_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o,
    output logic [W-1:0] y_vld_o,
    output logic [W-1:0] y_t_o,
    output logic [W-1:0] y_f_o
);

    logic         mask;
    logic         mask_step;
    logic         tree_idle;
    logic         m_t, m_f;
    logic [W-1:0] a_t, a_f, b_t, b_f, c_t, c_f;
    logic [W-1:0] g1_t, g1_f, g2_t, g2_f;

    // mask refresh only in precharge once the whole tree is back at 00
    always_comb begin
        tree_idle = ~|{g1_t, g1_f, g2_t, g2_f};
        mask_step = !eval_i && tree_idle;
        m_t       = eval_i & mask;
        m_f       = eval_i & ~mask;
    end

    mdr_mask_src #(
        .LW   (MASK_W),
        .TAPS (MASK_TAPS),
        .SEED (MASK_SEED)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (mask_step),
        .mask_o (mask)
    );

    mdr_encoder #(.W(W)) u_enc_a (
        .drv_i (eval_i & a_drv_i), .mask_i (mask), .d_i (a_i), .t_o (a_t), .f_o (a_f)
    );
    mdr_encoder #(.W(W)) u_enc_b (
        .drv_i (eval_i & b_drv_i), .mask_i (mask), .d_i (b_i), .t_o (b_t), .f_o (b_f)
    );
    mdr_encoder #(.W(W)) u_enc_c (
        .drv_i (eval_i & c_drv_i), .mask_i (mask), .d_i (c_i), .t_o (c_t), .f_o (c_f)
    );

    mdr_maj_gate #(.W(W)) u_gate_ab (
        .clk   (clk),  .rst_n (rst_n),
        .a_t_i (a_t),  .a_f_i (a_f),
        .b_t_i (b_t),  .b_f_i (b_f),
        .m_t_i (m_t),  .m_f_i (m_f),
        .q_t_o (g1_t), .q_f_o (g1_f)
    );

    mdr_maj_gate #(.W(W)) u_gate_abc (
        .clk   (clk),  .rst_n (rst_n),
        .a_t_i (g1_t), .a_f_i (g1_f),
        .b_t_i (c_t),  .b_f_i (c_f),
        .m_t_i (m_t),  .m_f_i (m_f),
        .q_t_o (g2_t), .q_f_o (g2_f)
    );

    // unmasking decoder
    always_comb begin
        y_vld_o = g2_t ^ g2_f;
        y_o     = (g2_t ^ {W{mask}}) & y_vld_o;
        y_t_o   = g2_t;
        y_f_o   = g2_f;
    end

    AST_MASK_FROZEN_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|y_vld_o) |=> $stable(mask) || !(|$past(y_vld_o)));               // R5
    AST_SHARED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (&y_vld_o) |-> ((y_t_o == y_o) || (y_t_o == ~y_o)));               // R4

endmodule

// File: tb/mdr_and3_bench.sv
module mdr_and3_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         eval_i = 1'b0;
    logic         a_drv_i = 1'b0, b_drv_i = 1'b0, c_drv_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0, c_i = '0;
    logic [W-1:0] y_o, y_vld_o, y_t_o, y_f_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mdr_and3 u_mdr_and3 (
        .clk (clk), .rst_n (rst_n), .eval_i (eval_i),
        .a_drv_i (a_drv_i), .b_drv_i (b_drv_i), .c_drv_i (c_drv_i),
        .a_i (a_i), .b_i (b_i), .c_i (c_i),
        .y_o (y_o), .y_vld_o (y_vld_o), .y_t_o (y_t_o), .y_f_o (y_f_o)
    );

    // {a, b, c, expected a&b&c}
    localparam logic [15:0] VEC [8] = '{
        16'hFFFF, 16'h0FF0, 16'hF0F0, 16'hFF00,
        16'hACE8, 16'h57D5, 16'h36F2, 16'h9B99
    };

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic precharge();
        eval_i = 1'b0; a_drv_i = 1'b0; b_drv_i = 1'b0; c_drv_i = 1'b0;
        cyc(4);
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        a_i = a; b_i = b; c_i = c;
        eval_i = 1'b1; a_drv_i = 1'b1; b_drv_i = 1'b1; c_drv_i = 1'b1;
        cyc(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] ref_y;
        logic [W-1:0] held;
        bit seen_pos, seen_neg;
        cyc(3);
        chk(y_vld_o == '0 && y_t_o == '0 && y_f_o == '0, "R1 in reset", y_vld_o, '0);
        rst_n = 1'b1;
        cyc(2);
        chk(y_vld_o == '0 && y_o == '0, "R1 after reset", y_o, '0);
        chk(y_t_o == '0 && y_f_o == '0, "R1 rails after reset", y_t_o, '0);

        // vector table
        for (int k = 0; k < 8; k++) begin
            precharge();
            apply(VEC[k][15:12], VEC[k][11:8], VEC[k][7:4]);
            chk(y_vld_o == '1, "R2 valid", y_vld_o, '1);
            chk(y_o == VEC[k][3:0], "R2 data", y_o, VEC[k][3:0]);
            chk((y_t_o ^ y_f_o) == '1, "R3 complementary", y_t_o ^ y_f_o, '1);
            chk(y_t_o == y_o || y_t_o == ~y_o, "R4 shared mask", y_t_o, y_o);
        end

        // R9: precharge returns in two edges
        eval_i = 1'b0; a_drv_i = 1'b0; b_drv_i = 1'b0; c_drv_i = 1'b0;
        cyc(2);
        chk(y_vld_o == '0 && y_t_o == '0 && y_f_o == '0, "R9 precharged", y_vld_o, '0);
        chk(y_o == '0, "R9 data cleared", y_o, '0);
        cyc(2);

        // R6: one operand undriven at first level, driven operand is 0
        a_i = '0; b_i = '1; c_i = '1;
        eval_i = 1'b1; a_drv_i = 1'b1; b_drv_i = 1'b0; c_drv_i = 1'b1;
        cyc(4);
        chk(y_vld_o == '0, "R6 no early eval level1", y_vld_o, '0);
        b_drv_i = 1'b1;
        cyc(2);
        chk(y_vld_o == '1 && y_o == '0, "R6 eval after arrival level1", y_o, '0);
        precharge();

        // R6: last operand arrives at second level
        a_i = 4'hF; b_i = 4'h6; c_i = 4'h0;
        eval_i = 1'b1; a_drv_i = 1'b1; b_drv_i = 1'b1; c_drv_i = 1'b0;
        cyc(4);
        chk(y_vld_o == '0, "R6 no early eval level2", y_vld_o, '0);
        c_i = 4'h3; c_drv_i = 1'b1;
        cyc(1);
        chk(y_vld_o == '1 && y_o == 4'h2, "R6 one edge after last pair", y_o, 4'h2);

        // R8: data change after evaluation ignored
        a_i = 4'h0; b_i = 4'h0; c_i = 4'hF;
        cyc(3);
        chk(y_vld_o == '1 && y_o == 4'h2, "R8 data change ignored", y_o, 4'h2);

        // R7: removing drives while mask pair present keeps output
        held = y_o;
        a_drv_i = 1'b0;
        cyc(3);
        chk(y_vld_o == '1 && y_o == held, "R7 partial removal", y_o, held);
        b_drv_i = 1'b0; c_drv_i = 1'b0;
        cyc(3);
        chk(y_vld_o == '1 && y_o == held, "R7 mask pair still valid", y_o, held);
        eval_i = 1'b0;
        cyc(2);
        chk(y_vld_o == '0, "R9 precharge after mask pair leaves", y_vld_o, '0);
        cyc(2);

        // R5: mask refresh across rounds of identical data
        seen_pos = 1'b0; seen_neg = 1'b0;
        for (int r = 0; r < 16; r++) begin
            precharge();
            apply(4'hF, 4'hF, 4'hF);
            ref_y = 4'hF;
            if (y_t_o == ref_y) seen_pos = 1'b1;
            if (y_t_o == ~ref_y) seen_neg = 1'b1;
        end
        chk(seen_pos && seen_neg, "R5 mask polarity varies", {2'b00, seen_pos, seen_neg}, 4'h3);
        chk(y_o == 4'hF, "R2 data after refresh rounds", y_o, 4'hF);

        precharge();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule